// File: doc/BRIEF.md
# Pulse Counter with Compare Flag

This block counts events on one selected source and raises a sticky flag when the count reaches a programmable compare value. The source is either a pre-filtered single-cycle strobe, or a raw level that the block edge-detects. A compare event occurs when an increment arrives while the count already equals the compare value. On a compare event the block sets the flag and emits a one-cycle trigger. The counter then either returns to zero or, in free-running mode, keeps counting.

The controller is a four-state machine that combines the enable with the flag. ST_OFF_CLEAR means disabled with the flag clear. ST_OFF_FLAGGED means disabled with the flag set. ST_RUN_CLEAR means counting with the flag clear. ST_RUN_FLAGGED means counting with the flag set.

The transitions are as follows:
- *arm* (enable rises, from OFF_CLEAR to RUN_CLEAR)
- *arm_flagged* (OFF_FLAGGED to RUN_FLAGGED)
- *park* (enable falls, from RUN_CLEAR to OFF_CLEAR)
- *park_flagged* (RUN_FLAGGED to OFF_FLAGGED)
- *match* (a compare event, from any state to RUN_FLAGGED)
- *ack* (the flag-clear strobe with no compare event, from a FLAGGED state to the CLEAR state for the current enable)

The compare value can only be rewritten safely. The block takes a write when it is disabled, or while the flag is set.

Top module: `pulse_cnt_cmp`

## Requirements
- R1: After reset the count, flag, interrupt request and trigger are all 0, and the compare value is 0.
- R2: With byp_sel=0 and en=1, each clock edge at which evt_strobe=1 adds one to the count; raw_in has no effect.
- R3: With byp_sel=1 and en=1, each 0-to-1 change of raw_in between two consecutive clock edges adds one to the count; evt_strobe has no effect.
- R4: With byp_sel=1, a raw_in that is already 1 in the first enabled cycle causes no increment.
- R5: When an increment occurs while the count equals the compare value, cmp_flag is 1 after that edge.
- R6: On a compare event the count becomes 0 if free_run=0, or count+1 (mod 2^16, so 0xFFFF wraps to 0) if free_run=1.
- R7: trig is 1 for exactly the one cycle after each compare event edge, and 0 otherwise.
- R8: irq equals cmp_flag AND irq_en.
- R9: flag_clr clears cmp_flag at the next edge, unless a compare event occurs at that same edge, in which case the flag stays 1.
- R10: A cmp_wr is taken when en=0 at any time, and when en=1 only if cmp_flag is 1; otherwise the write is dropped.
- R11: While en=0 the count is held at 0 and no compare event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Counter enable |
| evt_strobe | input | 1 | Filtered increment strobe, one cycle per event |
| byp_sel | input | 1 | 1 selects the edge-detected raw_in |
| raw_in | input | 1 | Raw source level, synchronous to clk |
| cmp_val | input | 16 | Compare value to be written |
| cmp_wr | input | 1 | Compare value write strobe |
| irq_en | input | 1 | Interrupt enable |
| free_run | input | 1 | 1 keeps counting through a compare event |
| flag_clr | input | 1 | Flag clear strobe |
| count | output | 16 | Current count |
| cmp_flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |
| trig | output | 1 | One-cycle trigger pulse |

## Verification
A flag-clear strobe and a new compare event can land at the same edge, and so can a compare-value write and a compare event. The bench first brings the count to the compare value. It then drives evt_strobe together with flag_clr in one cycle, and expects the flag to stay set, the count to return to 0 and the trigger to pulse. A write offered while the flag is clear must be dropped. The bench judges this by the count at which the next compare event fires.

// File: rtl/pc_pkg.sv
package pc_pkg;
    typedef enum logic [1:0] {
        ST_OFF_CLEAR   = 2'b00,
        ST_OFF_FLAGGED = 2'b01,
        ST_RUN_CLEAR   = 2'b10,
        ST_RUN_FLAGGED = 2'b11
    } pc_state_e;
endpackage

// File: rtl/pc_inc_src.sv
// Selects the increment source; edge-detects the raw level in bypass mode.
module pc_inc_src (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic byp_sel,
    input  logic raw_in,
    input  logic evt_strobe,
    output logic inc
);
    logic raw_prev;

    // Previous level is forced high while disabled, so an already-high
    // source does not look like a fresh edge when counting starts.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   raw_prev <= 1'b1;
        else if (!en) raw_prev <= 1'b1;
        else          raw_prev <= raw_in;
    end

    always_comb begin
        if (!en)          inc = 1'b0;
        else if (byp_sel) inc = raw_in & ~raw_prev;
        else              inc = evt_strobe;
    end
endmodule

// File: rtl/pc_cmp_reg.sv
// Compare value holding register with a write-acceptance gate.
module pc_cmp_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             wr_ok,
    input  logic [CNT_W-1:0] din,
    output logic [CNT_W-1:0] cmp_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cmp_q <= '0;
        else if (wr && wr_ok) cmp_q <= din;
    end
endmodule

// File: rtl/pc_count.sv
// Event counter and compare-event detection.
module pc_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             inc,
    input  logic             free_run,
    input  logic [CNT_W-1:0] cmp_q,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign hit = inc & (count == cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                count <= '0;
        else if (!en)              count <= '0;
        else if (hit && !free_run) count <= '0;
        else if (inc)              count <= count + ONE;
    end
endmodule

// File: rtl/pc_ctrl.sv
// Flag/enable state machine, trigger pulse and write gate.
module pc_ctrl
    import pc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hit,
    input  logic flag_clr,
    output logic flag,
    output logic trig,
    output logic wr_ok
);
    pc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF_CLEAR: begin
                if (hit)     state_d = ST_RUN_FLAGGED;   // match
                else if (en) state_d = ST_RUN_CLEAR;     // arm
            end
            ST_OFF_FLAGGED: begin
                if (hit)           state_d = ST_RUN_FLAGGED;                      // match
                else if (flag_clr) state_d = en ? ST_RUN_CLEAR : ST_OFF_CLEAR;    // ack
                else if (en)       state_d = ST_RUN_FLAGGED;                      // arm_flagged
            end
            ST_RUN_CLEAR: begin
                if (hit)      state_d = ST_RUN_FLAGGED;  // match
                else if (!en) state_d = ST_OFF_CLEAR;    // park
            end
            ST_RUN_FLAGGED: begin
                if (hit)           state_d = ST_RUN_FLAGGED;                      // match
                else if (flag_clr) state_d = en ? ST_RUN_CLEAR : ST_OFF_CLEAR;    // ack
                else if (!en)      state_d = ST_OFF_FLAGGED;                      // park_flagged
            end
            default: state_d = ST_OFF_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig <= 1'b0;
        else        trig <= hit;
    end

    always_comb begin
        flag  = (state_q == ST_OFF_FLAGGED) || (state_q == ST_RUN_FLAGGED);
        wr_ok = !en || flag;
    end
endmodule

// File: rtl/pulse_cnt_cmp.sv
module pulse_cnt_cmp #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             evt_strobe,
    input  logic             byp_sel,
    input  logic             raw_in,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cmp_wr,
    input  logic             irq_en,
    input  logic             free_run,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             cmp_flag,
    output logic             irq,
    output logic             trig
);
    logic             inc;
    logic             hit;
    logic             wr_ok;
    logic [CNT_W-1:0] cmp_q;

    pc_inc_src u_src (
        .clk(clk), .rst_n(rst_n), .en(en), .byp_sel(byp_sel),
        .raw_in(raw_in), .evt_strobe(evt_strobe), .inc(inc)
    );

    pc_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .wr(cmp_wr), .wr_ok(wr_ok),
        .din(cmp_val), .cmp_q(cmp_q)
    );

    pc_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .inc(inc), .free_run(free_run),
        .cmp_q(cmp_q), .count(count), .hit(hit)
    );

    pc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .hit(hit), .flag_clr(flag_clr),
        .flag(cmp_flag), .trig(trig), .wr_ok(wr_ok)
    );

    assign irq = cmp_flag & irq_en;
endmodule

// File: rtl/pulse_cnt_cmp_chk.sv
module pulse_cnt_cmp_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             free_run,
    input logic [CNT_W-1:0] count,
    input logic             cmp_flag,
    input logic             irq,
    input logic             trig
);
    // R5: the flag only rises together with a trigger pulse
    a_r5_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_flag) |-> trig);

    // R9: a compare event always leaves the flag set, even against a clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> cmp_flag);

    // R8: no interrupt without the flag
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cmp_flag);

    // R11: disabled holds the count at zero and produces no trigger
    a_r11_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count == '0) && !trig);

    // R6: without free-running mode a compare event returns the count to zero
    a_r6_reset_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !$past(free_run)) |-> (count == '0));

    // R2: outside a compare event the count only steps by one
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !trig && (count != $past(count)))
            |-> (count == CNT_W'($past(count) + 1'b1)));
endmodule

bind pulse_cnt_cmp pulse_cnt_cmp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .free_run(free_run),
    .count(count), .cmp_flag(cmp_flag), .irq(irq), .trig(trig)
);

// File: tb/pulse_cnt_cmp_bench.sv
`timescale 1ns/1ps
module pulse_cnt_cmp_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, evt_strobe = 1'b0, byp_sel = 1'b0, raw_in = 1'b0;
    logic [15:0] cmp_val = '0;
    logic        cmp_wr = 1'b0, irq_en = 1'b0, free_run = 1'b0, flag_clr = 1'b0;
    logic [15:0] count;
    logic        cmp_flag, irq, trig;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pulse_cnt_cmp u_pulse_cnt_cmp (
        .clk(clk), .rst_n(rst_n), .en(en), .evt_strobe(evt_strobe),
        .byp_sel(byp_sel), .raw_in(raw_in), .cmp_val(cmp_val), .cmp_wr(cmp_wr),
        .irq_en(irq_en), .free_run(free_run), .flag_clr(flag_clr),
        .count(count), .cmp_flag(cmp_flag), .irq(irq), .trig(trig)
    );

    // Vector: {en, byp_sel, raw_in, evt_strobe, expected count}
    localparam int NV = 13;
    localparam logic [19:0] VEC [NV] = '{
        {4'b1001, 16'd1},   // R2 strobe counts
        {4'b1010, 16'd1},   // R2 raw ignored
        {4'b1001, 16'd2},   // R2
        {4'b1011, 16'd3},   // R2
        {4'b0001, 16'd0},   // R11 disabled holds zero
        {4'b0110, 16'd0},   // R11
        {4'b1110, 16'd0},   // R4 already high at enable
        {4'b1111, 16'd0},   // R3 strobe ignored in bypass
        {4'b1100, 16'd0},   // R3
        {4'b1110, 16'd1},   // R3 rising edge
        {4'b1110, 16'd1},   // R3 level held
        {4'b1101, 16'd1},   // R3
        {4'b1110, 16'd2}    // R3 rising edge
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then settle after the rising edge.
    task automatic cyc(input logic e, input logic b, input logic r, input logic v,
                       input logic c, input logic w, input logic [15:0] val);
        @(negedge clk);
        en = e; byp_sel = b; raw_in = r; evt_strobe = v;
        flag_clr = c; cmp_wr = w; cmp_val = val;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1 count", 32'(count), 0);
        chk("R1 flag",  32'(cmp_flag), 0);
        chk("R1 irq",   32'(irq), 0);
        chk("R1 trig",  32'(trig), 0);
        rst_n = 1'b1;

        // R1 compare value resets to 0: first increment is a compare event
        cyc(1, 0, 0, 1, 0, 0, 0);
        chk("R1 cmp0 count", 32'(count), 0);
        chk("R5 cmp0 flag",  32'(cmp_flag), 1);
        chk("R7 cmp0 trig",  32'(trig), 1);
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R9 clear flag", 32'(cmp_flag), 0);
        chk("R7 trig ends",  32'(trig), 0);
        cyc(0, 0, 0, 0, 0, 1, 16'd1000);   // R10 write while disabled

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16], 0, 0, 0);
            chk($sformatf("R2/R3/R4/R11 vector %0d count", i), 32'(count), 32'(VEC[i][15:0]));
            chk($sformatf("vector %0d no flag", i), 32'(cmp_flag), 0);
        end

        // R10 accepted while disabled; R5, R6, R7 compare event
        cyc(0, 0, 0, 0, 0, 1, 16'd3);
        cyc(1, 0, 0, 1, 0, 0, 0);
        cyc(1, 0, 0, 1, 0, 0, 0);
        cyc(1, 0, 0, 1, 0, 0, 0);
        chk("R5 no event at equal", 32'(cmp_flag), 0);
        chk("R2 count 3", 32'(count), 3);
        cyc(1, 0, 0, 1, 0, 0, 0);
        chk("R6 count zero", 32'(count), 0);
        chk("R5 flag set",   32'(cmp_flag), 1);
        chk("R7 trig high",  32'(trig), 1);
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk("R7 trig one cycle", 32'(trig), 0);
        chk("R5 flag sticky",    32'(cmp_flag), 1);

        // R8 interrupt request
        chk("R8 irq masked", 32'(irq), 0);
        irq_en = 1'b1; #1;
        chk("R8 irq raised", 32'(irq), 1);

        // R10 write taken while flag set, dropped while flag clear
        cyc(1, 0, 0, 0, 0, 1, 16'd2);
        cyc(1, 0, 0, 0, 1, 0, 0);
        chk("R9 flag cleared", 32'(cmp_flag), 0);
        chk("R8 irq follows",  32'(irq), 0);
        cyc(1, 0, 0, 0, 0, 1, 16'd5);
        cyc(1, 0, 0, 1, 0, 0, 0);
        cyc(1, 0, 0, 1, 0, 0, 0);
        cyc(1, 0, 0, 1, 0, 0, 0);
        chk("R10 write dropped count", 32'(count), 0);
        chk("R10 write dropped flag",  32'(cmp_flag), 1);

        // R9 clear and compare event together: event wins
        cyc(1, 0, 0, 0, 1, 0, 0);
        cyc(1, 0, 0, 1, 0, 0, 0);
        cyc(1, 0, 0, 1, 0, 0, 0);
        chk("R9 precondition", 32'(cmp_flag), 0);
        cyc(1, 0, 0, 1, 1, 0, 0);
        chk("R9 set wins flag", 32'(cmp_flag), 1);
        chk("R9 set wins trig", 32'(trig), 1);
        chk("R9 set wins count", 32'(count), 0);
        cyc(1, 0, 0, 0, 1, 0, 0);
        chk("R9 later clear", 32'(cmp_flag), 0);

        // R6 free-running continues past the compare value
        free_run = 1'b1;
        cyc(1, 0, 0, 1, 0, 0, 0);
        cyc(1, 0, 0, 1, 0, 0, 0);
        cyc(1, 0, 0, 1, 0, 0, 0);
        chk("R6 free count", 32'(count), 3);
        chk("R6 free flag",  32'(cmp_flag), 1);
        cyc(1, 0, 0, 0, 1, 0, 0);

        // R6 wrap from all-ones in free-running mode
        cyc(0, 0, 0, 0, 0, 1, 16'hFFFF);
        @(negedge clk);
        en = 1'b1; evt_strobe = 1'b1; cmp_wr = 1'b0; flag_clr = 1'b0;
        repeat (65535) @(posedge clk);
        #2;
        chk("R6 reach all-ones", 32'(count), 32'hFFFF);
        chk("R6 no early flag",  32'(cmp_flag), 0);
        cyc(1, 0, 0, 1, 0, 0, 0);
        chk("R6 wrap count", 32'(count), 0);
        chk("R6 wrap flag",  32'(cmp_flag), 1);
        chk("R7 wrap trig",  32'(trig), 1);

        // R11 disabled ignores strobes
        cyc(0, 0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk("R11 held zero", 32'(count), 0);
        chk("R11 no trig",   32'(trig), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule